// File: doc/BRIEF.md
# Time-Compare Event Source Selector

This block turns one of several timing conditions into a single-cycle event pulse. A 5-bit mode input picks the source. The choices are: no source, a software trigger alone, a greater-or-equal comparison of BCD calendar time with per-field masking, a greater-or-equal comparison of straight-binary time, an internal period tick, a digital PLL tick, or one of 24 external digital event lines. Every level-type condition becomes a pulse only on its rising transition, so a condition that stays true fires once.

The chip uses two copies of the block. One generates events and the other resets a counter. The two copies differ only in the software register bit that drives `sw_trig`. Masking the upper BCD fields gives yearly, monthly, daily, hourly or per-minute repeating events from a single set time.

Top module: `evt_src_sel`

## Requirements
- R1: With mode 0 the pulse never asserts, whatever the other inputs do.
- R2: With mode 1 only `sw_trig` counts. A rising `sw_trig` sampled at one clock edge drives `evt_pulse` high for the cycle after that edge.
- R3: In modes 2, 3, 4, 6 and 8 to 31, the software bit is ORed with the hardware condition before edge detection. When both rise in the same cycle, only one pulse is produced.
- R4: Mode 2 fires when the BCD time `bcd_now` is greater than or equal to `bcd_set`. Both are packed as second in bits 7:0, minute in 15:8, hour in 23:16, day in 31:24, month in 39:32 and year in 47:40, two BCD digits per field. The comparison is lexicographic from year down to second. Setting `bcd_mask` bit i makes field i compare as equal.
- R5: Mode 3 fires when `bin_now` is greater than or equal to `bin_set`, compared as unsigned values.
- R6: Mode 4 takes its condition from `period_tick` and mode 6 takes it from `pll_tick`.
- R7: Modes 5 and 7 are reserved and never fire, and the software bit is also ignored in them.
- R8: Modes 8 to 31 select event line (mode − 8). Each line passes through two synchronizing flops. A line that is high at clock edge k produces a pulse visible after edge k+2.
- R9: A pulse lasts exactly one cycle. A condition that stays true does not fire again until it has gone low and risen once more.
- R10: In the cycle after `mode` changes, the pulse is suppressed. The condition that is current at that moment is taken as already seen, so a source that is already true when selected does not fire.
- R11: While `rst_n` is low, `evt_pulse` is low and all edge history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Source select |
| sw_trig | input | 1 | Software trigger bit |
| bcd_now | input | 48 | Current BCD time |
| bcd_set | input | 48 | BCD set time |
| bcd_mask | input | 6 | Per-field BCD compare mask, bit 0 = seconds |
| bin_now | input | 32 | Current straight-binary time |
| bin_set | input | 32 | Binary set time |
| period_tick | input | 1 | Internal period counter tick |
| pll_tick | input | 1 | Digital PLL tick |
| evt_lines | input | 24 | External digital event lines |
| evt_pulse | output | 1 | Single-cycle event output |

## Verification
Two functions can fall in the same cycle. The first case is a software trigger that rises together with a hardware compare. The bench raises `sw_trig` in the same cycle that the binary time crosses its set value. It then expects exactly one pulse, and no further pulse while either bit stays high. The second case is a mode change that coincides with a condition that is already true. The bench switches to a compare that is already satisfied, and to a line that is already held high. It requires silence there, and a pulse only after a later fresh rise.

// File: rtl/evt_src_sel.sv
module evt_src_sel #(
  parameter int MODE_W = 5,
  parameter int LINES  = 24,
  parameter int FIELDS = 6,
  parameter int FW     = 8,
  parameter int BIN_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MODE_W-1:0]       mode,
  input  logic                    sw_trig,
  input  logic [FIELDS*FW-1:0]    bcd_now,
  input  logic [FIELDS*FW-1:0]    bcd_set,
  input  logic [FIELDS-1:0]       bcd_mask,
  input  logic [BIN_W-1:0]        bin_now,
  input  logic [BIN_W-1:0]        bin_set,
  input  logic                    period_tick,
  input  logic                    pll_tick,
  input  logic [LINES-1:0]        evt_lines,
  output logic                    evt_pulse
);
  localparam logic [MODE_W-1:0] M_OFF  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_SW   = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_BCD  = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_BIN  = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_PER  = MODE_W'(4);
  localparam logic [MODE_W-1:0] M_RSA  = MODE_W'(5);
  localparam logic [MODE_W-1:0] M_PLL  = MODE_W'(6);
  localparam logic [MODE_W-1:0] M_RSB  = MODE_W'(7);
  localparam logic [MODE_W-1:0] M_LINE = MODE_W'(8);

  logic [LINES-1:0]  sync1, sync2;
  logic [MODE_W-1:0] mode_q;
  logic              lvl_q;
  logic              bcd_gt, bcd_lt, bcd_ge, bin_ge;
  logic [MODE_W-1:0] line_idx;
  logic              line_lvl, hw_lvl, lvl, blocked;

  always_comb begin
    bcd_gt = 1'b0;
    bcd_lt = 1'b0;
    for (int i = FIELDS-1; i >= 0; i--) begin
      if (!bcd_mask[i] && !bcd_gt && !bcd_lt) begin
        if (bcd_now[i*FW +: FW] > bcd_set[i*FW +: FW])      bcd_gt = 1'b1;
        else if (bcd_now[i*FW +: FW] < bcd_set[i*FW +: FW]) bcd_lt = 1'b1;
      end
    end
  end
  assign bcd_ge = !bcd_lt;
  assign bin_ge = bin_now >= bin_set;

  assign line_idx = mode - M_LINE;
  always_comb begin
    line_lvl = 1'b0;
    if (mode >= M_LINE)
      for (int i = 0; i < LINES; i++)
        if (int'(line_idx) == i) line_lvl = sync2[i];
  end

  always_comb begin
    case (mode)
      M_BCD:   hw_lvl = bcd_ge;
      M_BIN:   hw_lvl = bin_ge;
      M_PER:   hw_lvl = period_tick;
      M_PLL:   hw_lvl = pll_tick;
      default: hw_lvl = line_lvl;
    endcase
  end

  assign blocked = (mode == M_OFF) || (mode == M_RSA) || (mode == M_RSB);
  assign lvl     = !blocked && (sw_trig || (mode != M_SW && hw_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      mode_q    <= M_OFF;
      lvl_q     <= 1'b0;
      evt_pulse <= 1'b0;
    end else begin
      sync1     <= evt_lines;
      sync2     <= sync1;
      mode_q    <= mode;
      lvl_q     <= lvl;
      evt_pulse <= lvl && !lvl_q && (mode == mode_q);
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF) |=> !evt_pulse); // R1
  AST_SW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SW && mode_q == M_SW && sw_trig && !lvl_q) |=> evt_pulse); // R2
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RSA || mode == M_RSB) |=> !evt_pulse); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse); // R9
  AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> !evt_pulse); // R10
endmodule

// File: tb/evt_src_sel_tb.sv
`timescale 1ns/1ps
module evt_src_sel_tb;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  mode = 0;
  logic        sw_trig = 0;
  logic [47:0] bcd_now = 0, bcd_set = 0;
  logic [5:0]  bcd_mask = 0;
  logic [31:0] bin_now = 0, bin_set = 0;
  logic        period_tick = 0, pll_tick = 0;
  logic [23:0] evt_lines = 0;
  logic        evt_pulse;

  int nchk = 0, nerr = 0, cnt = 0;
  bit done = 0;
  string cur_req = "R11";

  evt_src_sel u_dut (.clk(clk), .rst_n(rst_n), .mode(mode), .sw_trig(sw_trig),
    .bcd_now(bcd_now), .bcd_set(bcd_set), .bcd_mask(bcd_mask), .bin_now(bin_now),
    .bin_set(bin_set), .period_tick(period_tick), .pll_tick(pll_tick),
    .evt_lines(evt_lines), .evt_pulse(evt_pulse));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic longint bcd_key(input logic [47:0] t, input logic [5:0] m);
    longint k = 0;
    for (int f = 5; f >= 0; f--) begin
      int v = (m[f]) ? 0 : int'(t[f*8+4 +: 4]) * 10 + int'(t[f*8 +: 4]);
      k = k * 100 + v;
    end
    return k;
  endfunction

  logic [23:0] lh[$];
  logic [4:0]  pm;
  bit          pl, expp;
  always @(posedge clk) begin
    if (!rst_n) begin
      lh.delete(); pm = 0; pl = 0; expp = 0;
    end else begin
      logic [23:0] seen;
      bit hw, lv;
      seen = (lh.size() >= 2) ? lh[lh.size()-2] : 24'd0;
      case (mode)
        2: hw = bcd_key(bcd_now, bcd_mask) >= bcd_key(bcd_set, bcd_mask);
        3: hw = bin_now >= bin_set;
        4: hw = period_tick;
        6: hw = pll_tick;
        default: hw = (mode >= 8) ? seen[mode-8] : 1'b0;
      endcase
      if (mode == 0 || mode == 5 || mode == 7) lv = 0;
      else if (mode == 1) lv = sw_trig;
      else lv = sw_trig | hw;
      expp = lv && !pl && (mode == pm);
      pl = lv; pm = mode;
      lh.push_back(evt_lines);
      if (lh.size() > 4) void'(lh.pop_front());
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(evt_pulse === expp, cur_req, evt_pulse, expp);
    if (evt_pulse) cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_cnt(input string req, input int e);
    chk(cnt == e, req, cnt, e);
    cnt = 0;
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    cyc(3);
    chk(evt_pulse === 1'b0, "R11", evt_pulse, 0);
    rst_n = 1;
    cyc(2);
    cnt = 0;

    cur_req = "R1";
    sw_trig = 1; cyc(1); sw_trig = 0; period_tick = 1; pll_tick = 1; cyc(1);
    period_tick = 0; pll_tick = 0; evt_lines = 24'hFFFFFF; bin_set = 5; bin_now = 9; cyc(4);
    evt_lines = 0; bin_now = 0; cyc(3);
    expect_cnt("R1", 0);

    cur_req = "R2"; mode = 1; cyc(2);
    sw_trig = 1; cyc(1); sw_trig = 0; cyc(2);
    sw_trig = 1; cyc(1); sw_trig = 0; cyc(2);
    cur_req = "R9";
    sw_trig = 1; cyc(5); sw_trig = 0; cyc(3);
    expect_cnt("R2", 3);

    cur_req = "R6"; mode = 4; cyc(2);
    repeat (3) begin period_tick = 1; cyc(1); period_tick = 0; cyc(2); end
    expect_cnt("R6", 3);
    mode = 6; cyc(2);
    pll_tick = 1; cyc(1); pll_tick = 0; period_tick = 1; cyc(1); period_tick = 0; cyc(2);
    pll_tick = 1; cyc(1); pll_tick = 0; cyc(2);
    expect_cnt("R6", 2);

    cur_req = "R5"; bin_set = 1000; bin_now = 0; mode = 3; cyc(2);
    for (int v = 990; v <= 1010; v++) begin bin_now = v; cyc(1); end
    bin_now = 500; cyc(2); bin_now = 1000; cyc(3);
    expect_cnt("R5", 2);

    cur_req = "R4"; bin_now = 0;
    bcd_mask = 6'b111000; bcd_set = 48'h250615_123000; bcd_now = 48'h240101_122959;
    mode = 2; cyc(2);
    bcd_now = 48'h240101_123000; cyc(3);
    bcd_now = 48'h240102_000000; cyc(2);
    bcd_now = 48'h240102_123005; cyc(3);
    expect_cnt("R4", 2);
    bcd_mask = 6'b111110; bcd_set = 48'h000000_000030; bcd_now = 48'h990101_235929; cyc(2);
    bcd_now = 48'h990101_235931; cyc(3);
    bcd_now = 48'h990101_235905; cyc(2);
    bcd_now = 48'h990101_235930; cyc(3);
    expect_cnt("R4", 2);
    bcd_mask = 6'b000000; bcd_set = 48'h250101_000000; bcd_now = 48'h241231_235959; cyc(3);
    bcd_now = 48'h250101_000000; cyc(3);
    expect_cnt("R4", 1);

    cur_req = "R3"; bcd_now = 0; bin_set = 1000; bin_now = 0; mode = 3; cyc(2);
    sw_trig = 1; cyc(1); sw_trig = 0; cyc(2);
    sw_trig = 1; bin_now = 2000; cyc(3);
    sw_trig = 0; cyc(2); bin_now = 0; cyc(2);
    expect_cnt("R3", 2);

    cur_req = "R7";
    for (int r = 5; r <= 7; r += 2) begin
      mode = 5'(r); cyc(2);
      repeat (3) begin sw_trig = 1; cyc(1); sw_trig = 0; cyc(1); end
      period_tick = 1; pll_tick = 1; cyc(1); period_tick = 0; pll_tick = 0; cyc(2);
    end
    expect_cnt("R7", 0);

    cur_req = "R8";
    for (int j = 0; j < 3; j++) begin
      int k = (j == 0) ? 0 : (j == 1) ? 5 : 23;
      evt_lines = 0; mode = 5'(8 + k); cyc(3);
      evt_lines[k] = 1; cyc(1); evt_lines = 0; cyc(5);
      evt_lines[(k + 1) % 24] = 1; cyc(1); evt_lines = 0; cyc(5);
      expect_cnt("R8", 1);
    end

    cur_req = "R10"; mode = 1; bin_set = 1000; bin_now = 2000; cyc(2);
    mode = 3; cyc(3);
    evt_lines[4] = 1; cyc(3); mode = 12; cyc(5);
    evt_lines[4] = 0; cyc(3); evt_lines[4] = 1; cyc(5);
    expect_cnt("R10", 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule